// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN protocol controller is in and what status it shows while it gets there. The four modes are DISABLED, FROZEN, SYNCING and NORMAL. After a hard reset the controller is DISABLED. Clearing the disable bit takes it into FROZEN, never straight into NORMAL. Software releases it from FROZEN by clearing the halt bit. The controller then waits in SYNCING until the bus is seen idle, and only after that enters NORMAL. The transmit line is driven recessive in every mode except NORMAL. Two configuration fields are protected by mode: the clock-source select can be written only in DISABLED, and the timing word (bit-timing fields, prescaler and arbitration select) only in FROZEN.

A soft reset is started by a bit in the mode register. The request travels to the protocol clock domain and back as a four-phase request/acknowledge handshake, with two-flop synchronizers in each direction. The pending flag stays up until the handshake has fully returned to idle, so software can poll it. The request is refused while the low-power clock-stop indication is high, and also while an earlier soft reset is still pending. A soft reset zeroes the timing word and sets halt and freeze. If the controller is not disabled, it goes back to FROZEN. The disable bit and the clock source are kept, and message storage outside this block is not touched. A request to disable waits until any pending soft reset has finished.

The named transitions are as follows.
- enable: DISABLED to FROZEN.
- release: FROZEN to SYNCING.
- join: SYNCING to NORMAL.
- halt: NORMAL or SYNCING to FROZEN.
- shutdown: any mode to DISABLED.
- soft-reset return: any enabled mode to FROZEN.

Top module: `can_mode_seq`

## Requirements
- R1: After a hard reset the outputs are as follows: mode_o is 0 (DISABLED), disable, halt and freeze read 1, frz_ack_o is 0, not_rdy_o is 1, srst_busy_o is 0, clk_src_o is 0, timing_o is 0 and can_tx_o is 1. The mode encoding is DISABLED=0, FROZEN=1, SYNCING=2, NORMAL=3.
- R2: A write to address 0 sets disable from bit 0, freeze from bit 1 and halt from bit 2; bit 3 requests a soft reset. When the disable bit is written to 0 in DISABLED, the mode becomes FROZEN on the next clock, and halt and freeze are forced to 1 whatever value was written.
- R3: A write to address 1 loads the clock-source select from bit 0, but only while the mode is DISABLED. In any other mode the write is ignored.
- R4: A write to address 2 loads the whole timing word, but only while the mode is FROZEN. In any other mode the write is ignored.
- R5: When halt is 0 in FROZEN, the mode becomes SYNCING on the next clock and frz_ack_o drops with it. not_rdy_o stays 1 for as long as bus_idle is low. The first clock that samples bus_idle high moves the mode to NORMAL, and not_rdy_o becomes 0.
- R6: When halt and freeze are both 1 in SYNCING or NORMAL, the mode becomes FROZEN on the next clock.
- R7: can_tx_o is 1 in every mode except NORMAL, and follows proto_tx in NORMAL. proto_run_o is 1 only in NORMAL.
- R8: An accepted soft-reset request raises srst_busy_o on the clock of the write. The flag clears by itself once the handshake completes. proto_srst_o pulses for exactly one protocol-clock cycle for each request.
- R9: When a soft reset completes, the timing word becomes 0, halt and freeze become 1, and an enabled controller returns to FROZEN. The clock-source select is not changed.
- R10: A soft-reset request made while clk_stop is 1 is ignored: srst_busy_o stays 0, no pulse is produced and the timing word is not changed.
- R11: Setting the disable bit in FROZEN, SYNCING or NORMAL gives DISABLED on the next clock when no soft reset is pending. While a soft reset is pending, the mode does not reach DISABLED until srst_busy_o has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous hard reset, active low, for both domains |
| pclk | input | 1 | Protocol-engine clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 clock source, 2 timing |
| wr_data | input | DATA_W | Write data |
| clk_stop | input | 1 | Low-power clock-stop indication |
| bus_idle | input | 1 | Bus-idle indication from the bit engine |
| proto_tx | input | 1 | Transmit bit from the protocol engine |
| mode_o | output | 2 | Current mode |
| dis_o | output | 1 | Disable bit |
| halt_o | output | 1 | Halt bit |
| frz_o | output | 1 | Freeze bit |
| frz_ack_o | output | 1 | Freeze acknowledge |
| not_rdy_o | output | 1 | Not synchronized to the bus |
| srst_busy_o | output | 1 | Soft reset pending |
| clk_src_o | output | 1 | Clock-source select |
| timing_o | output | DATA_W | Timing configuration word |
| can_tx_o | output | 1 | Transmit line, 1 = recessive |
| proto_run_o | output | 1 | Enable for the protocol state machines |
| proto_srst_o | output | 1 | Soft-reset pulse in the protocol clock domain |

## Verification
The bench sweeps every mode and, in each one, tries both the clock-source write and the timing write. A design with a wrong gate would change the clock-source select or the timing word in the wrong mode. The bench keeps bus_idle low in SYNCING over several clocks, to catch a design that reaches NORMAL, or drops not-ready, before the bus has been seen idle. It starts a disable while a soft reset is still in flight. A design that ignores the pending flag would enter DISABLED early, and one that never lets the disable through would stay enabled. It also requests a soft reset with the clocks stopped, and counts the pulses on the protocol side, so a refused request that is acted on, or a doubled pulse, shows up.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MS_DISABLED = 2'd0,
        MS_FROZEN   = 2'd1,
        MS_SYNCING  = 2'd2,
        MS_NORMAL   = 2'd3
    } mode_state_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_SRC  = 2'd1;
    localparam logic [1:0] ADDR_TIM  = 2'd2;

    localparam int BIT_DIS  = 0;
    localparam int BIT_FRZ  = 1;
    localparam int BIT_HALT = 2;
    localparam int BIT_SRST = 3;
    localparam int MODE_W   = 4;

endpackage

// File: rtl/can_srst_xdc.sv
module can_srst_xdc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pclk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic srst_pulse
);
    // host side
    logic                   req_q;
    logic [SYNC_STAGES-1:0] ack_sync_q;
    logic                   ack_seen;

    // protocol side
    logic [SYNC_STAGES-1:0] req_sync_q;
    logic                   req_seen;
    logic                   ack_q;
    logic                   pulse_q;

    assign ack_seen = ack_sync_q[SYNC_STAGES-1];
    assign req_seen = req_sync_q[SYNC_STAGES-1];
    assign done     = req_q & ack_seen;
    assign busy     = req_q | ack_seen;
    assign srst_pulse = pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (start) begin
            req_q <= 1'b1;
        end else if (done) begin
            req_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_sync_q <= '0;
        end else begin
            ack_sync_q <= {ack_sync_q[SYNC_STAGES-2:0], ack_q};
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            req_sync_q <= '0;
            ack_q      <= 1'b0;
            pulse_q    <= 1'b0;
        end else begin
            req_sync_q <= {req_sync_q[SYNC_STAGES-2:0], req_q};
            ack_q      <= req_seen;
            pulse_q    <= req_seen & ~ack_q;
        end
    end

    // R8: the request stays up until its acknowledge returns
    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack_seen) |=> req_q);

    // R8: one protocol-clock pulse per request
    p_one_pulse_r8: assert property (@(posedge pclk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/can_mode_cfg.sv
module can_mode_cfg
    import can_mode_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_state_e       state,
    input  logic              src_wr,
    input  logic              tim_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              srst_done,
    output logic              clk_src,
    output logic [DATA_W-1:0] timing
);
    logic src_ok;
    logic tim_ok;

    assign src_ok = src_wr && (state == MS_DISABLED);
    assign tim_ok = tim_wr && (state == MS_FROZEN);

    // clock source: only hard reset clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_src <= 1'b0;
        end else if (src_ok) begin
            clk_src <= wr_data[0];
        end
    end

    // timing word: soft reset wins over a write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing <= '0;
        end else if (srst_done) begin
            timing <= '0;
        end else if (tim_ok) begin
            timing <= wr_data;
        end
    end

    p_src_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MS_DISABLED) |=> $stable(clk_src));

    p_timing_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MS_FROZEN && !srst_done) |=> $stable(timing));

    p_timing_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_done |=> (timing == '0));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_d,
    input  logic              bus_idle,
    input  logic              clk_stop,
    input  logic              srst_busy,
    input  logic              srst_done,
    output mode_state_e       state,
    output logic              dis_q,
    output logic              frz_q,
    output logic              halt_q,
    output logic              srst_start,
    output logic              frz_ack,
    output logic              not_rdy,
    output logic              run,
    output logic              tx_pass
);
    mode_state_e state_q;
    mode_state_e state_d;
    logic        enter_frz;
    logic        hold_req;
    logic        shut_ok;

    assign state      = state_q;
    assign hold_req   = halt_q & frz_q;
    assign shut_ok    = dis_q & ~srst_busy;
    assign enter_frz  = (state_q == MS_DISABLED) && (state_d == MS_FROZEN);
    assign srst_start = mode_wr & mode_d[BIT_SRST] & ~clk_stop & ~srst_busy;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_DISABLED: begin
                if (!srst_done && !dis_q) state_d = MS_FROZEN;     // enable
            end
            MS_FROZEN: begin
                if (srst_done)       state_d = MS_FROZEN;          // soft-reset return
                else if (shut_ok)    state_d = MS_DISABLED;        // shutdown
                else if (!halt_q)    state_d = MS_SYNCING;         // release
            end
            MS_SYNCING: begin
                if (srst_done)       state_d = MS_FROZEN;
                else if (shut_ok)    state_d = MS_DISABLED;
                else if (hold_req)   state_d = MS_FROZEN;          // halt
                else if (bus_idle)   state_d = MS_NORMAL;          // join
            end
            MS_NORMAL: begin
                if (srst_done)       state_d = MS_FROZEN;
                else if (shut_ok)    state_d = MS_DISABLED;
                else if (hold_req)   state_d = MS_FROZEN;
            end
            default:                 state_d = MS_DISABLED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    // mode control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (mode_wr) begin
            dis_q <= mode_d[BIT_DIS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frz_q  <= 1'b1;
            halt_q <= 1'b1;
        end else if (srst_done || enter_frz) begin
            frz_q  <= 1'b1;
            halt_q <= 1'b1;
        end else if (mode_wr) begin
            frz_q  <= mode_d[BIT_FRZ];
            halt_q <= mode_d[BIT_HALT];
        end
    end

    // per-state outputs
    always_comb begin
        frz_ack = 1'b0;
        not_rdy = 1'b1;
        run     = 1'b0;
        tx_pass = 1'b0;
        unique case (state_q)
            MS_DISABLED: ;
            MS_FROZEN:   frz_ack = 1'b1;
            MS_SYNCING:  ;
            MS_NORMAL: begin
                not_rdy = 1'b0;
                run     = 1'b1;
                tx_pass = 1'b1;
            end
            default: ;
        endcase
    end

    p_enable_lands_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_DISABLED && !dis_q && !srst_done)
            |=> (state_q == MS_FROZEN && halt_q && frz_q));

    p_join_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_SYNCING && !bus_idle) |=> (state_q != MS_NORMAL));

    p_halt_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_NORMAL && hold_req && !dis_q) |=> (state_q == MS_FROZEN));

    p_srst_returns_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_done && state_q != MS_DISABLED) |=> (state_q == MS_FROZEN && halt_q));

    p_disable_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MS_DISABLED && srst_busy) |=> (state_q != MS_DISABLED));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clk_stop,
    input  logic              bus_idle,
    input  logic              proto_tx,
    output logic [1:0]        mode_o,
    output logic              dis_o,
    output logic              halt_o,
    output logic              frz_o,
    output logic              frz_ack_o,
    output logic              not_rdy_o,
    output logic              srst_busy_o,
    output logic              clk_src_o,
    output logic [DATA_W-1:0] timing_o,
    output logic              can_tx_o,
    output logic              proto_run_o,
    output logic              proto_srst_o
);
    mode_state_e state;
    logic        mode_wr;
    logic        src_wr;
    logic        tim_wr;
    logic        srst_start;
    logic        srst_busy;
    logic        srst_done;
    logic        tx_pass;

    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
    assign src_wr  = wr_en && (wr_addr == ADDR_SRC);
    assign tim_wr  = wr_en && (wr_addr == ADDR_TIM);

    can_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_d     (wr_data[MODE_W-1:0]),
        .bus_idle   (bus_idle),
        .clk_stop   (clk_stop),
        .srst_busy  (srst_busy),
        .srst_done  (srst_done),
        .state      (state),
        .dis_q      (dis_o),
        .frz_q      (frz_o),
        .halt_q     (halt_o),
        .srst_start (srst_start),
        .frz_ack    (frz_ack_o),
        .not_rdy    (not_rdy_o),
        .run        (proto_run_o),
        .tx_pass    (tx_pass)
    );

    can_srst_xdc #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_xdc (
        .clk        (clk),
        .pclk       (pclk),
        .rst_n      (rst_n),
        .start      (srst_start),
        .busy       (srst_busy),
        .done       (srst_done),
        .srst_pulse (proto_srst_o)
    );

    can_mode_cfg #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .src_wr    (src_wr),
        .tim_wr    (tim_wr),
        .wr_data   (wr_data),
        .srst_done (srst_done),
        .clk_src   (clk_src_o),
        .timing    (timing_o)
    );

    assign mode_o      = state;
    assign srst_busy_o = srst_busy;
    assign can_tx_o    = tx_pass ? proto_tx : 1'b1;

    p_srst_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop && !srst_busy) |=> !srst_busy);

    p_tx_recessive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MS_NORMAL) |-> (can_tx_o && !proto_run_o));

endmodule

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int PCLK_PERIOD = 14;
    localparam int DW          = 16;

    logic          clk = 1'b0;
    logic          pclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          clk_stop = 1'b0;
    logic          bus_idle = 1'b0;
    logic          proto_tx = 1'b0;
    logic [1:0]    mode_o;
    logic          dis_o, halt_o, frz_o, frz_ack_o, not_rdy_o, srst_busy_o;
    logic          clk_src_o, can_tx_o, proto_run_o, proto_srst_o;
    logic [DW-1:0] timing_o;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(PCLK_PERIOD/2) pclk = ~pclk;

    always @(negedge pclk) if (proto_srst_o) pulses++;

    can_mode_seq #(.DATA_W(DW)) u_can_mode_seq (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_stop(clk_stop), .bus_idle(bus_idle),
        .proto_tx(proto_tx), .mode_o(mode_o), .dis_o(dis_o), .halt_o(halt_o),
        .frz_o(frz_o), .frz_ack_o(frz_ack_o), .not_rdy_o(not_rdy_o),
        .srst_busy_o(srst_busy_o), .clk_src_o(clk_src_o), .timing_o(timing_o),
        .can_tx_o(can_tx_o), .proto_run_o(proto_run_o), .proto_srst_o(proto_srst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_idle = 1'b0; clk_stop = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
    endtask

    // walk from DISABLED to mode s
    task automatic go_mode(input int s);
        if (s >= 1) begin wr(2'd0, 16'h0006); tick(1); end
        if (s >= 2) begin bus_idle = 1'b0; wr(2'd0, 16'h0002); tick(1); end
        if (s >= 3) begin bus_idle = 1'b1; tick(1); bus_idle = 1'b0; end
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (srst_busy_o && cyc < 200) begin
            tick(1);
            cyc++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        int p0;
        hard_reset();
        // R1 reset state
        check("R1 mode", mode_o, 0);
        check("R1 dis/halt/frz", {dis_o, halt_o, frz_o}, 3'b111);
        check("R1 ack/nrdy", {frz_ack_o, not_rdy_o}, 2'b01);
        check("R1 busy", srst_busy_o, 0);
        check("R1 src/timing", {clk_src_o, timing_o}, 0);
        check("R1 tx", can_tx_o, 1);

        // sweep every mode: R3, R4, R7
        for (int s = 0; s < 4; s++) begin
            hard_reset();
            go_mode(s);
            check("R2/R5 reach mode", mode_o, s);
            check("R5 frz_ack", frz_ack_o, (s == 1));
            check("R5 not_rdy", not_rdy_o, (s != 3));
            wr(2'd1, 16'h0001);
            check("R3 clk_src gate", clk_src_o, (s == 0));
            wr(2'd2, 16'hA5C0 + DW'(s));
            check("R4 timing gate", timing_o, (s == 1) ? (32'hA5C0 + s) : 0);
            proto_tx = 1'b0; tick(1);
            check("R7 tx low in", can_tx_o, (s == 3) ? 0 : 1);
            proto_tx = 1'b1; tick(1);
            check("R7 tx high in", can_tx_o, 1);
            check("R7 run", proto_run_o, (s == 3));
        end

        // R2: enable forces halt and freeze even if written 0
        hard_reset();
        wr(2'd0, 16'h0000);
        check("R2 still disabled after write", mode_o, 0);
        tick(1);
        check("R2 enable lands frozen", mode_o, 1);
        check("R2 halt/frz forced", {halt_o, frz_o}, 2'b11);

        // R5: SYNCING waits for bus idle
        hard_reset(); go_mode(1);
        bus_idle = 1'b0;
        wr(2'd0, 16'h0002);
        check("R5 frz_ack before edge", frz_ack_o, 1);
        tick(1);
        check("R5 syncing", mode_o, 2);
        check("R5 frz_ack dropped", frz_ack_o, 0);
        tick(4);
        check("R5 waits idle", {mode_o, not_rdy_o}, {2'd2, 1'b1});
        bus_idle = 1'b1; tick(1); bus_idle = 1'b0;
        check("R5 joined", {mode_o, not_rdy_o}, {2'd3, 1'b0});

        // R6 from NORMAL and from SYNCING
        wr(2'd0, 16'h0006); tick(1);
        check("R6 normal to frozen", mode_o, 1);
        wr(2'd0, 16'h0002); tick(1);
        check("R6 setup syncing", mode_o, 2);
        wr(2'd0, 16'h0006); tick(1);
        check("R6 syncing to frozen", mode_o, 1);

        // R11 without pending reset
        wr(2'd0, 16'h0007); tick(1);
        check("R11 shutdown", mode_o, 0);

        // R8 / R9 soft reset from NORMAL
        hard_reset();
        wr(2'd1, 16'h0001);
        go_mode(1);
        wr(2'd2, 16'h1234);
        go_mode_tail: begin
            wr(2'd0, 16'h0002); tick(1);
            bus_idle = 1'b1; tick(1); bus_idle = 1'b0;
        end
        check("R9 setup normal", mode_o, 3);
        p0 = pulses;
        wr(2'd0, 16'h000A);
        check("R8 busy set", srst_busy_o, 1);
        wait_idle(cyc);
        check("R8 busy self-clears", (cyc < 200), 1);
        tick(2);
        check("R8 one pulse", pulses - p0, 1);
        check("R9 frozen", mode_o, 1);
        check("R9 halt/frz", {halt_o, frz_o}, 2'b11);
        check("R9 timing cleared", timing_o, 0);
        check("R9 clk_src kept", clk_src_o, 1);

        // R10 refused while clocks stopped
        wr(2'd2, 16'h0F0F);
        p0 = pulses;
        clk_stop = 1'b1;
        wr(2'd0, 16'h000E);
        check("R10 busy stays low", srst_busy_o, 0);
        tick(12);
        check("R10 busy still low", srst_busy_o, 0);
        check("R10 no pulse", pulses - p0, 0);
        check("R10 timing kept", timing_o, 16'h0F0F);
        clk_stop = 1'b0;

        // R11 disable waits for pending reset
        p0 = pulses;
        wr(2'd0, 16'h000E);
        wr(2'd0, 16'h0007);
        tick(1);
        check("R11 held while busy", {(mode_o != 0), srst_busy_o}, 2'b11);
        wait_idle(cyc);
        tick(1);
        check("R11 disabled after busy", mode_o, 0);
        check("R8 second pulse", pulses - p0, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule